// File: doc/BRIEF.md
# Compare Flags and Branch Condition Unit

This block subtracts one operand from another in two's complement, or ANDs the two operands bitwise, and keeps four status flags taken from the result: carry, sign, zero and overflow. The flags are held in registers. They change only on a cycle in which the update strobe is high. Each cycle, a 4-bit condition select picks one branch test. The block evaluates that test on the held flags and drives a single take-branch output.

Tests on unsigned magnitude (higher, lower) and tests on signed magnitude (greater, less) both come from the same four flags of one subtraction. A sequencer can therefore issue one compare and then ask about either interpretation of the operands in any later cycle. The take output follows the condition select combinationally, so a new select gives a new answer in the same cycle.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is held, and until the first update after reset, all four flags read 0.
- R2: When the update strobe is low at a rising clock edge, all four flags keep their values, whatever the operands and mode inputs are.
- R3: On an update with mode 0 (subtract), the result is M + ~N + 1. C takes the carry out of the top bit, S takes the top bit of the result, and Z is 1 exactly when the result is all zeros.
- R4: On a subtract update, V is 1 exactly when the carry into the top bit differs from the carry out of it. This is the same as the signed difference falling outside the operand range.
- R5: On an update with mode 1 (test), S and Z take their values from M AND N, and C and V are cleared.
- R6: The unsigned condition codes are 3 (higher: C=1 and Z=0), 4 (higher or same: C=1), 5 (lower: C=0) and 6 (lower or same: C=0 or Z=1).
- R7: The signed condition codes are 7 (greater: S^V=0 and Z=0), 8 (greater or equal: S^V=0), 9 (less: S^V=1) and 10 (less or equal: S^V=1 or Z=1).
- R8: The remaining condition codes are 0 (always), 1 (equal: Z=1), 2 (not equal: Z=0), 11 (minus: S=1), 12 (plus: S=0), 13 (overflow: V=1), 14 (no overflow: V=0) and 15 (never).
- R9: Three worked cases hold. For M=0xF0 and N=0x14, the flags are C=1, S=1, Z=0 and V=0. For M=60 and N=10, codes 3, 4 and 2 are taken. For M=-8 and N=10, codes 9, 10 and 2 are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| upd | input | 1 | Update strobe: the flags load on a rising edge while this is high |
| mode_test | input | 1 | 0 selects subtract, 1 selects bitwise AND test |
| opnd_m | input | W | Minuend M |
| opnd_n | input | W | Subtrahend N |
| cond_sel | input | 4 | Branch condition code |
| flag_c | output | 1 | Held carry flag |
| flag_s | output | 1 | Held sign flag |
| flag_z | output | 1 | Held zero flag |
| flag_v | output | 1 | Held overflow flag |
| take | output | 1 | Branch decision for the selected code |

## Verification
The bench builds the block with the default width W=8. At that width every operand pair lies within 65,536 combinations, so a few hundred random draws, together with directed edge values, reach the sign-boundary pairs that produce overflow in both directions. The directed values are 0x7F against 0xFF, 0x80 against 0x01, equal operands, and zero. For each update, all sixteen condition codes are swept and compared against plain signed and unsigned comparisons of the operands.

// File: rtl/cmp_branch_pkg.sv
package cmp_branch_pkg;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_HI     = 4'd3,
    CC_HS     = 4'd4,
    CC_LO     = 4'd5,
    CC_LS     = 4'd6,
    CC_GT     = 4'd7,
    CC_GE     = 4'd8,
    CC_LT     = 4'd9,
    CC_LE     = 4'd10,
    CC_MI     = 4'd11,
    CC_PL     = 4'd12,
    CC_VS     = 4'd13,
    CC_VC     = 4'd14,
    CC_NEVER  = 4'd15
  } cond_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/cbu_rst_sync.sv
module cbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbu_flag_calc.sv
module cbu_flag_calc
  import cmp_branch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         mode_test,
  input  logic [W-1:0] opnd_m,
  input  logic [W-1:0] opnd_n,
  output flags_t       flags_new
);
  localparam int LOW_W = W - 1;

  logic [W:0]     full_sum;
  logic [LOW_W:0] low_sum;
  logic [W-1:0]   and_res;
  logic           carry_into_top;

  always_comb begin
    full_sum       = {1'b0, opnd_m} + {1'b0, ~opnd_n} + {{W{1'b0}}, 1'b1};
    low_sum        = {1'b0, opnd_m[LOW_W-1:0]} + {1'b0, ~opnd_n[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, 1'b1};
    carry_into_top = low_sum[LOW_W];
    and_res        = opnd_m & opnd_n;
    if (mode_test) begin
      flags_new.c = 1'b0;
      flags_new.s = and_res[W-1];
      flags_new.z = (and_res == '0);
      flags_new.v = 1'b0;
    end else begin
      flags_new.c = full_sum[W];
      flags_new.s = full_sum[W-1];
      flags_new.z = (full_sum[W-1:0] == '0);
      flags_new.v = full_sum[W] ^ carry_into_top;
    end
  end
endmodule

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cmp_branch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  flags_t flags_in,
  output flags_t flags_q
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_en) flags_d = flags_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cmp_branch_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] cond_sel,
  output logic       take
);
  logic lt_signed;

  always_comb begin
    lt_signed = flags.s ^ flags.v;
    unique case (cond_e'(cond_sel))
      CC_ALWAYS: take = 1'b1;
      CC_EQ:     take = flags.z;
      CC_NE:     take = !flags.z;
      CC_HI:     take = flags.c && !flags.z;
      CC_HS:     take = flags.c;
      CC_LO:     take = !flags.c;
      CC_LS:     take = !flags.c || flags.z;
      CC_GT:     take = !lt_signed && !flags.z;
      CC_GE:     take = !lt_signed;
      CC_LT:     take = lt_signed;
      CC_LE:     take = lt_signed || flags.z;
      CC_MI:     take = flags.s;
      CC_PL:     take = !flags.s;
      CC_VS:     take = flags.v;
      CC_VC:     take = !flags.v;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cmp_branch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         mode_test,
  input  logic [W-1:0] opnd_m,
  input  logic [W-1:0] opnd_n,
  input  logic [3:0]   cond_sel,
  output logic         flag_c,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_v,
  output logic         take
);
  logic   rst_int_n;
  flags_t flags_new;
  flags_t flags_q;

  cbu_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cbu_flag_calc #(.W(W)) u_calc (
    .mode_test(mode_test), .opnd_m(opnd_m), .opnd_n(opnd_n),
    .flags_new(flags_new)
  );

  cbu_flag_reg u_freg (
    .clk(clk), .rst_n(rst_int_n), .load_en(upd),
    .flags_in(flags_new), .flags_q(flags_q)
  );

  cbu_cond_eval u_ceval (
    .flags(flags_q), .cond_sel(cond_sel), .take(take)
  );

  assign flag_c = flags_q.c;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_int_n,
  input logic         upd,
  input logic         mode_test,
  input logic [W-1:0] opnd_m,
  input logic [W-1:0] opnd_n,
  input logic [3:0]   cond_sel,
  input logic         flag_c,
  input logic         flag_s,
  input logic         flag_z,
  input logic         flag_v,
  input logic         take
);
  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !upd |=> $stable({flag_c, flag_s, flag_z, flag_v}));

  // R3
  sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd && !mode_test) |=> (flag_z == ($past(opnd_m) == $past(opnd_n))));

  // R4
  sub_ovf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd && !mode_test) |=> (flag_v == (($past(opnd_m[W-1]) != $past(opnd_n[W-1]))
                                        && (flag_s != $past(opnd_m[W-1])))));

  // R5
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd && mode_test) |=> (!flag_c && !flag_v));

  // R6
  unsigned_hi_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cond_sel == 4'd3 && take) |-> (flag_c && !flag_z));

  // R7
  signed_lt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cond_sel == 4'd9 && take) |-> (flag_s != flag_v));

  // R8
  never_code_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cond_sel == 4'd15) |-> !take);
endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .upd(upd), .mode_test(mode_test),
  .opnd_m(opnd_m), .opnd_n(opnd_n), .cond_sel(cond_sel),
  .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_v(flag_v),
  .take(take)
);

// File: tb/cmp_branch_unit_tb.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         upd = 1'b0;
  logic         mode_test = 1'b0;
  logic [W-1:0] opnd_m = '0;
  logic [W-1:0] opnd_n = '0;
  logic [3:0]   cond_sel = '0;
  logic         flag_c, flag_s, flag_z, flag_v, take;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  cmp_branch_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd(upd), .mode_test(mode_test),
    .opnd_m(opnd_m), .opnd_n(opnd_n), .cond_sel(cond_sel),
    .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_v(flag_v),
    .take(take)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // returns {c,s,z,v}
  function automatic logic [3:0] model_flags(input logic [7:0] m, input logic [7:0] n,
                                             input logic tst);
    logic [7:0] r;
    int sd;
    if (tst) begin
      r = m & n;
      return {1'b0, r[7], (r == 8'd0), 1'b0};
    end
    r  = m - n;
    sd = int'($signed(m)) - int'($signed(n));
    return {(m >= n), r[7], (m == n), (sd > 127 || sd < -128)};
  endfunction

  function automatic logic model_cond(input int k, input logic [7:0] m,
                                      input logic [7:0] n, input logic [3:0] f);
    case (k)
      0:  return 1'b1;
      1:  return m == n;
      2:  return m != n;
      3:  return m > n;
      4:  return m >= n;
      5:  return m < n;
      6:  return m <= n;
      7:  return $signed(m) >  $signed(n);
      8:  return $signed(m) >= $signed(n);
      9:  return $signed(m) <  $signed(n);
      10: return $signed(m) <= $signed(n);
      11: return f[2];
      12: return !f[2];
      13: return f[0];
      14: return !f[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int k);
    if (k >= 3 && k <= 6)  return "R6";
    if (k >= 7 && k <= 10) return "R7";
    return "R8";
  endfunction

  task automatic do_update(input logic [7:0] m, input logic [7:0] n, input logic tst);
    @(negedge clk);
    opnd_m = m; opnd_n = n; mode_test = tst; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic check_op(input logic [7:0] m, input logic [7:0] n, input logic tst);
    logic [3:0] f;
    f = model_flags(m, n, tst);
    do_update(m, n, tst);
    check(tst ? "R5" : "R3", "flag_c", flag_c, f[3]);
    check(tst ? "R5" : "R3", "flag_s", flag_s, f[2]);
    check(tst ? "R5" : "R3", "flag_z", flag_z, f[1]);
    check(tst ? "R5" : "R4", "flag_v", flag_v, f[0]);
    if (!tst) begin
      for (int k = 0; k < 16; k++) begin
        cond_sel = k[3:0];
        #1;
        check(req_of(k), $sformatf("take code %0d", k), take, model_cond(k, m, n, f));
      end
    end
  endtask

  initial begin
    logic [3:0] held;
    logic [7:0] rm, rn;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "flags in reset", {flag_c, flag_s, flag_z, flag_v}, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "flags after reset", {flag_c, flag_s, flag_z, flag_v}, 4'h0);
    cond_sel = 4'd5; #1;
    check("R1", "lower taken from reset flags", take, 1'b1);

    // R9 worked cases
    check_op(8'hF0, 8'h14, 1'b0);
    check("R9", "flags F0-14", {flag_c, flag_s, flag_z, flag_v}, 4'b1100);
    do_update(8'd60, 8'd10, 1'b0);
    cond_sel = 4'd3; #1; check("R9", "60 vs 10 higher", take, 1'b1);
    cond_sel = 4'd4; #1; check("R9", "60 vs 10 higher-same", take, 1'b1);
    cond_sel = 4'd2; #1; check("R9", "60 vs 10 not equal", take, 1'b1);
    do_update(8'hF8, 8'd10, 1'b0);
    cond_sel = 4'd9;  #1; check("R9", "-8 vs 10 less", take, 1'b1);
    cond_sel = 4'd10; #1; check("R9", "-8 vs 10 less-equal", take, 1'b1);
    cond_sel = 4'd2;  #1; check("R9", "-8 vs 10 not equal", take, 1'b1);

    // directed corners
    check_op(8'h7F, 8'hFF, 1'b0);
    check_op(8'h80, 8'h01, 1'b0);
    check_op(8'h55, 8'h55, 1'b0);
    check_op(8'h00, 8'h00, 1'b0);
    check_op(8'h00, 8'h80, 1'b0);
    check_op(8'hF0, 8'h0F, 1'b1);
    check_op(8'h80, 8'hC0, 1'b1);

    // R2 hold with strobe low
    check_op(8'h10, 8'h20, 1'b0);
    held = {flag_c, flag_s, flag_z, flag_v};
    @(negedge clk);
    opnd_m = 8'h33; opnd_n = 8'h33; mode_test = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", "flags held", {flag_c, flag_s, flag_z, flag_v}, held);
    mode_test = 1'b0;

    // random
    for (int i = 0; i < 400; i++) begin
      rm = 8'($urandom);
      rn = ($urandom % 8 == 0) ? rm : 8'($urandom);
      check_op(rm, rn, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule